// File: doc/BRIEF.md
# Triggered Multi-Pin Sample Packer

The block watches a bus of input pins and turns a group of them into a stream of 32-bit capture words. An arm pulse stores the configuration and puts the block in a waiting state. The configuration covers the first pin of the group, the group size, the trigger pin and its level, a clock divider and the number of words to capture. While it waits, the block looks at the trigger pin on every clock. In the first cycle that the trigger pin shows the requested level, the block takes the first sample of the group. After that it takes one sample every divider period.

Each sample shifts in from the top of a 32-bit shift register, so older samples move toward bit 0. A word is released once the register holds as many whole samples as fit in 32 bits. When the group size does not divide 32, the released word is left-justified and its unused low bits are zero. A capture buffer writer downstream can find any sample bit from the group size alone.

Words leave through a valid/ready port. A word that has been offered stays on the port unchanged until it is accepted. Sampling never stalls. If a new word completes while the held word is still unaccepted, the new word is dropped and a sticky overflow flag is set. The capture ends once the requested number of words has been accepted.

Top module: `pin_sample_packer`

## Requirements
- R1: A sample holds group-size bits. Bit i of the sample is pin ((base + i) mod 32). A group size of 0 is treated as 1, and a group size above 32 is treated as 32.
- R2: A word is released when the register holds T = 32 − (32 mod n) bits, where n is the group size. Within a word, pin p of the j-th sample sits at bit (32 − T) + p + j·n. The low 32 − T bits are zero.
- R3: After an arm, no sample is taken until a cycle in which the trigger pin equals the trigger level. The pins seen in that cycle form sample 0.
- R4: After sample 0, one sample is taken every D clocks. D is the divider value, and a divider of 0 or 1 gives D = 1.
- R5: Sampling stops once W words have been loaded into the output, where W is the word count and a count of 0 is treated as 1. The capture completes when the W-th word is accepted.
- R6: While m_valid_o is high and m_ready_i is low, the word is held with m_valid_o high and m_data_o unchanged.
- R7: A word that completes while an unaccepted word is held is dropped, and overflow_o goes high. overflow_o stays high until the next arm. Sampling continues, and the dropped word does not count toward W.
- R8: busy_o is high from the clock edge that takes an arm until the clock edge that accepts the final word. On that final edge done_o rises, and it stays high until the next arm. busy_o and done_o are never high together.
- R9: An arm while a capture is busy restarts the capture. It discards the held word, the partial word, the counts and both flags.
- R10: After reset, m_valid_o, busy_o, done_o and overflow_o are all low.
- R11: The configuration is taken only on the arm edge. Changes to the configuration inputs during a capture have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins_i | input | 32 | Pin bus being sampled |
| cfg_base_i | input | 5 | First pin of the sampled group |
| cfg_count_i | input | 6 | Group size n (0 means 1, above 32 means 32) |
| cfg_trig_pin_i | input | 5 | Index of the trigger pin on pins_i |
| cfg_trig_level_i | input | 1 | Level the trigger pin must show |
| cfg_div_i | input | 16 | Clocks between samples (0 or 1 means every clock) |
| cfg_words_i | input | 16 | Number of words to capture (0 means 1) |
| arm_i | input | 1 | One-cycle pulse that stores the configuration and arms the block |
| m_ready_i | input | 1 | Downstream can accept a word |
| m_valid_o | output | 1 | A capture word is offered |
| m_data_o | output | 32 | Capture word |
| busy_o | output | 1 | Armed or capturing |
| done_o | output | 1 | Final word accepted, held until the next arm |
| overflow_o | output | 1 | Sticky flag: at least one word was dropped |

## Verification
The bench runs a cycle-accurate reference through each case and compares the outputs every cycle. It covers group sizes that do not divide 32 (3 and 5), the extremes 1 and 32, and sizes that must be clamped. A packer that always released at 32 bits, or that right-justified its words, would show misplaced sample bits or non-zero low bits. The trigger pin is held at the wrong level for several cycles and the divider is given the values 0 through 4. An off-by-one in the trigger cycle or in the divider period would put the wrong pin values into the words. Heavy back-pressure forces dropped words; a design that overwrote the held word, or that counted dropped words toward the total, would show a wrong word stream or finish early. Further cases re-arm in the middle of a capture and change the configuration inputs during a capture, to show that held or partial data and late configuration changes leak into nothing.

// File: rtl/spk_pkg.sv
package spk_pkg;
  parameter int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_DRAIN = 2'd3
  } spk_state_e;
endpackage

// File: rtl/spk_tick_gen.sv
module spk_tick_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear_i || start_i) begin
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= tick_o ? '0 : cnt_q + DIV_W'(1);
    end
  end

  // R4: the phase counter never passes the divider period
  p_phase_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < div_i));
endmodule

// File: rtl/spk_lane_sel.sv
module spk_lane_sel #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned SEL_W  = $clog2(NPINS),
  localparam int unsigned NCNT_W = $clog2(WORD_W + 1)
) (
  input  logic [NPINS-1:0]  pins_i,
  input  logic [SEL_W-1:0]  base_i,
  input  logic [NCNT_W-1:0] n_i,
  output logic [WORD_W-1:0] samp_o
);
  for (genvar g = 0; g < WORD_W; g++) begin : g_lane
    localparam int unsigned OFF = g % NPINS;
    logic [SEL_W:0]   sum;
    logic [SEL_W-1:0] idx;
    assign sum = {1'b0, base_i} + (SEL_W + 1)'(OFF);
    assign idx = (sum >= (SEL_W + 1)'(NPINS)) ? SEL_W'(sum - (SEL_W + 1)'(NPINS))
                                              : sum[SEL_W-1:0];
    assign samp_o[g] = (NCNT_W'(g) < n_i) ? pins_i[idx] : 1'b0;
  end
endmodule

// File: rtl/spk_packer.sv
module spk_packer #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned NCNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              en_i,
  input  logic [WORD_W-1:0] samp_i,
  input  logic [NCNT_W-1:0] n_i,
  input  logic [NCNT_W-1:0] thr_i,
  output logic              push_o,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sr_q;
  logic [NCNT_W-1:0] bc_q;
  logic [NCNT_W-1:0] bc_next;

  assign word_o  = (sr_q >> n_i) | (samp_i << (NCNT_W'(WORD_W) - n_i));
  assign bc_next = bc_q + n_i;
  assign push_o  = en_i && (bc_next == thr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      bc_q <= '0;
    end else if (clear_i) begin
      sr_q <= '0;
      bc_q <= '0;
    end else if (en_i) begin
      if (push_o) begin
        sr_q <= '0;
        bc_q <= '0;
      end else begin
        sr_q <= word_o;
        bc_q <= bc_next;
      end
    end
  end

  // R2: the fill level stays below the release threshold between samples
  p_fill_below_thr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (bc_q < thr_i));
endmodule

// File: rtl/spk_outstage.sv
module spk_outstage #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned WCNT_W = 16,
  localparam int unsigned NCNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              push_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [WCNT_W-1:0] words_i,
  input  logic [NCNT_W-1:0] thr_i,
  input  logic              m_ready_i,
  output logic              m_valid_o,
  output logic [WORD_W-1:0] m_data_o,
  output logic              overflow_o,
  output logic              last_load_o,
  output logic              final_accept_o
);
  logic [WCNT_W-1:0] issued_q;
  logic [WCNT_W-1:0] accepted_q;
  logic              accept;
  logic              load;
  logic              lost;
  logic [WORD_W-1:0] low_mask;

  assign accept         = m_valid_o && m_ready_i;
  assign load           = push_i && (!m_valid_o || m_ready_i);
  assign lost           = push_i && m_valid_o && !m_ready_i;
  assign last_load_o    = load && ((issued_q + WCNT_W'(1)) == words_i);
  assign final_accept_o = accept && ((accepted_q + WCNT_W'(1)) == words_i);
  assign low_mask       = (WORD_W'(1) << (NCNT_W'(WORD_W) - thr_i)) - WORD_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid_o  <= 1'b0;
      m_data_o   <= '0;
      overflow_o <= 1'b0;
      issued_q   <= '0;
      accepted_q <= '0;
    end else if (clear_i) begin
      m_valid_o  <= 1'b0;
      overflow_o <= 1'b0;
      issued_q   <= '0;
      accepted_q <= '0;
    end else begin
      if (load) begin
        m_data_o  <= word_i;
        m_valid_o <= 1'b1;
        issued_q  <= issued_q + WCNT_W'(1);
      end else if (accept) begin
        m_valid_o <= 1'b0;
      end
      if (accept) accepted_q <= accepted_q + WCNT_W'(1);
      if (lost)   overflow_o <= 1'b1;
    end
  end

  // R6: an offered word holds until taken
  p_hold_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid_o && !m_ready_i && !clear_i) |=> (m_valid_o && $stable(m_data_o)));
  // R7: the overflow flag is sticky until a new arm
  p_overflow_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_o && !clear_i) |=> overflow_o);
  // R2: the padding bits of an offered word are zero
  p_low_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid_o |-> ((m_data_o & low_mask) == '0));
  // R5: never more words loaded than requested
  p_issue_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issued_q <= words_i);
endmodule

// File: rtl/pin_sample_packer.sv
module pin_sample_packer #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned WCNT_W = 16,
  localparam int unsigned WORD_W = spk_pkg::WORD_W,
  localparam int unsigned SEL_W  = $clog2(NPINS),
  localparam int unsigned NCNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pins_i,
  input  logic [SEL_W-1:0]  cfg_base_i,
  input  logic [NCNT_W-1:0] cfg_count_i,
  input  logic [SEL_W-1:0]  cfg_trig_pin_i,
  input  logic              cfg_trig_level_i,
  input  logic [DIV_W-1:0]  cfg_div_i,
  input  logic [WCNT_W-1:0] cfg_words_i,
  input  logic              arm_i,
  input  logic              m_ready_i,
  output logic              m_valid_o,
  output logic [WORD_W-1:0] m_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              overflow_o
);
  import spk_pkg::*;

  spk_state_e        state_q;
  logic [SEL_W-1:0]  base_q;
  logic [SEL_W-1:0]  trig_q;
  logic              lvl_q;
  logic [NCNT_W-1:0] n_q;
  logic [NCNT_W-1:0] thr_q;
  logic [DIV_W-1:0]  div_q;
  logic [WCNT_W-1:0] words_q;
  logic              done_q;

  logic [NCNT_W-1:0] n_eff;
  logic [NCNT_W-1:0] thr_eff;
  logic              hit;
  logic              tick;
  logic              sample_en;
  logic [WORD_W-1:0] samp;
  logic              push;
  logic [WORD_W-1:0] word;
  logic              last_load;
  logic              final_accept;

  always_comb begin
    if (cfg_count_i == '0)                     n_eff = NCNT_W'(1);
    else if (cfg_count_i > NCNT_W'(WORD_W))    n_eff = NCNT_W'(WORD_W);
    else                                       n_eff = cfg_count_i;
    thr_eff = NCNT_W'(WORD_W) - (NCNT_W'(WORD_W) % n_eff);
  end

  assign hit       = (state_q == ST_ARMED) && !arm_i && (pins_i[trig_q] == lvl_q);
  assign sample_en = hit || tick;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      trig_q  <= '0;
      lvl_q   <= 1'b0;
      n_q     <= NCNT_W'(1);
      thr_q   <= NCNT_W'(WORD_W);
      div_q   <= DIV_W'(1);
      words_q <= WCNT_W'(1);
      done_q  <= 1'b0;
    end else if (arm_i) begin
      state_q <= ST_ARMED;
      base_q  <= cfg_base_i;
      trig_q  <= cfg_trig_pin_i;
      lvl_q   <= cfg_trig_level_i;
      n_q     <= n_eff;
      thr_q   <= thr_eff;
      div_q   <= (cfg_div_i < DIV_W'(2)) ? DIV_W'(1) : cfg_div_i;
      words_q <= (cfg_words_i == '0) ? WCNT_W'(1) : cfg_words_i;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ARMED: if (hit) state_q <= last_load ? ST_DRAIN : ST_RUN;
        ST_RUN:   if (last_load) state_q <= ST_DRAIN;
        ST_DRAIN: if (final_accept) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  spk_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (arm_i),
    .start_i (hit),
    .run_i   (state_q == ST_RUN),
    .div_i   (div_q),
    .tick_o  (tick)
  );

  spk_lane_sel #(.NPINS(NPINS), .WORD_W(WORD_W)) u_lanes (
    .pins_i (pins_i),
    .base_i (base_q),
    .n_i    (n_q),
    .samp_o (samp)
  );

  spk_packer #(.WORD_W(WORD_W)) u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (arm_i),
    .en_i    (sample_en),
    .samp_i  (samp),
    .n_i     (n_q),
    .thr_i   (thr_q),
    .push_o  (push),
    .word_o  (word)
  );

  spk_outstage #(.WORD_W(WORD_W), .WCNT_W(WCNT_W)) u_out (
    .clk            (clk),
    .rst_n          (rst_n),
    .clear_i        (arm_i),
    .push_i         (push),
    .word_i         (word),
    .words_i        (words_q),
    .thr_i          (thr_q),
    .m_ready_i      (m_ready_i),
    .m_valid_o      (m_valid_o),
    .m_data_o       (m_data_o),
    .overflow_o     (overflow_o),
    .last_load_o    (last_load),
    .final_accept_o (final_accept)
  );

  // R8: done stays up until the next arm
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !arm_i) |=> done_o);
  // R8: busy and done never overlap
  p_done_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && busy_o));
  // R3: nothing is offered while still waiting for the trigger
  p_quiet_while_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARMED) |-> !m_valid_o);
endmodule

// File: tb/pin_sample_packer_bench.sv
`timescale 1ns/1ps
module pin_sample_packer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic [4:0]  cfg_base = '0;
  logic [5:0]  cfg_count = 6'd1;
  logic [4:0]  cfg_trig = '0;
  logic        cfg_level = 1'b0;
  logic [15:0] cfg_div = 16'd1;
  logic [15:0] cfg_words = 16'd1;
  logic        arm = 1'b0;
  logic        rdy = 1'b0;
  logic        m_valid;
  logic [31:0] m_data;
  logic        busy, done, ovf;

  always #4 clk = ~clk;

  pin_sample_packer u_pin_sample_packer (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .cfg_base_i(cfg_base),
    .cfg_count_i(cfg_count), .cfg_trig_pin_i(cfg_trig), .cfg_trig_level_i(cfg_level),
    .cfg_div_i(cfg_div), .cfg_words_i(cfg_words), .arm_i(arm), .m_ready_i(rdy),
    .m_valid_o(m_valid), .m_data_o(m_data), .busy_o(busy), .done_o(done),
    .overflow_o(ovf)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // reference state
  int mstate = 0, mv = 0, movf = 0, mdone = 0;
  logic [31:0] mw = '0, wbuf = '0;
  int sj, issued, acc, mb, mn, mthr, mtrig, mD, mW, nxt, obs_acc;
  bit mlvl;
  int cyc = 0;
  bit arm_req = 0, jitter = 0;
  int hold_n = 0, rdy_pct = 100;

  function automatic int eff_n(int c);
    if (c == 0) return 1;
    if (c > 32) return 32;
    return c;
  endfunction

  function automatic int thr_of(int n);
    return 32 - (32 % n);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    bit hs, take, push;
    @(negedge clk);
    arm = arm_req;
    if (jitter && !arm_req) begin
      cfg_base = 5'($urandom); cfg_count = 6'($urandom); cfg_trig = 5'($urandom);
      cfg_level = 1'($urandom); cfg_div = 16'($urandom % 5); cfg_words = 16'($urandom % 7);
    end
    pins = $urandom();
    if (hold_n > 0) begin
      pins[mtrig] = ~mlvl;
      hold_n--;
    end
    rdy = (($urandom % 100) < rdy_pct);
    #1;
    chk(m_valid == (mv != 0), "R6 m_valid", {31'd0, m_valid}, mv);
    if (mv != 0) chk(m_data == mw, "R2 m_data (R1 R3 R4 R11)", m_data, mw);
    chk(busy == (mstate != 0), "R8 busy", {31'd0, busy}, (mstate != 0));
    chk(done == (mdone != 0), "R8 done", {31'd0, done}, mdone);
    chk(ovf == (movf != 0), "R7 overflow", {31'd0, ovf}, movf);
    if (arm) begin
      mb = cfg_base; mn = eff_n(cfg_count); mthr = thr_of(mn);
      mtrig = cfg_trig; mlvl = cfg_level;
      mD = (cfg_div < 2) ? 1 : int'(cfg_div);
      mW = (cfg_words == 0) ? 1 : int'(cfg_words);
      mstate = 1; mv = 0; wbuf = '0; sj = 0; issued = 0; acc = 0;
      movf = 0; mdone = 0; obs_acc = 0;
    end else begin
      hs = (mv != 0) && rdy;
      if (m_valid && rdy) obs_acc++;
      take = 0;
      if (mstate == 1 && pins[mtrig] == mlvl) begin
        take = 1; mstate = 2; nxt = cyc + mD;
      end else if (mstate == 2 && cyc == nxt) begin
        take = 1; nxt = cyc + mD;
      end
      push = 0;
      if (take) begin
        for (int p = 0; p < mn; p++) wbuf[(32 - mthr) + p + sj * mn] = pins[(mb + p) % 32];
        sj++;
        if (sj * mn == mthr) begin push = 1; sj = 0; end
      end
      if (push) begin
        if (mv == 0 || hs) begin
          mv = 1; mw = wbuf; issued++;
          if (issued == mW) mstate = 3;
        end else begin
          movf = 1;
        end
        wbuf = '0;
      end else if (hs) begin
        mv = 0;
      end
      if (hs) begin
        acc++;
        if (acc == mW) begin mstate = 0; mdone = 1; mv = 0; end
      end
    end
    cyc++;
  endtask

  task automatic set_cfg(input int cnt, input int base, input int trig, input bit lvl,
                         input int div, input int words, input int rpct);
    cfg_count = 6'(cnt); cfg_base = 5'(base); cfg_trig = 5'(trig); cfg_level = lvl;
    cfg_div = 16'(div); cfg_words = 16'(words); rdy_pct = rpct;
  endtask

  task automatic arm_and_run(input int hold, input bit jit, input int max_steps, input string tag);
    int n;
    jitter = 0;
    arm_req = 1; step(); arm_req = 0;
    hold_n = hold; jitter = jit;
    n = 0;
    while (mstate != 0 && n < max_steps) begin
      step();
      n++;
    end
    jitter = 0;
    if (max_steps >= 6000) begin
      chk(mstate == 0, {tag, " R5 capture finished"}, mstate, 0);
      chk(obs_acc == mW, {tag, " R5 accepted word count"}, obs_acc, mW);
      step();
      chk(done == 1'b1, {tag, " R8 done after final accept"}, {31'd0, done}, 1);
    end
  endtask

  initial begin : watchdog
    #(8 * 190000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog R5 actual=hung expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    chk(!m_valid && !busy && !done && !ovf, "R10 reset outputs", {28'd0, m_valid, busy, done, ovf}, 0);
    rst_n = 1'b1;
    #1;
    chk(!m_valid && !busy && !done && !ovf, "R10 after reset release", {28'd0, m_valid, busy, done, ovf}, 0);

    // directed corner cases
    set_cfg(2, 16, 17, 1, 1, 4, 100);  arm_and_run(6, 0, 6000, "basic n=2");
    set_cfg(3, 30, 5, 0, 0, 5, 100);   arm_and_run(4, 0, 6000, "R2 n=3 div0");
    set_cfg(32, 0, 31, 1, 2, 3, 70);   arm_and_run(3, 0, 6000, "R1 n=32");
    set_cfg(1, 9, 9, 0, 3, 2, 100);    arm_and_run(7, 0, 6000, "R4 n=1 div3");
    set_cfg(0, 4, 2, 1, 1, 0, 100);    arm_and_run(2, 0, 6000, "R1 n=0 words=0");
    set_cfg(40, 7, 1, 0, 4, 2, 50);    arm_and_run(5, 0, 6000, "R1 n clamp");
    set_cfg(5, 11, 3, 1, 1, 4, 100);   arm_and_run(0, 0, 6000, "R2 n=5");
    set_cfg(32, 3, 0, 1, 1, 4, 5);     arm_and_run(0, 0, 6000, "R7 forced loss");
    chk(ovf == 1'b1, "R7 overflow after forced loss", {31'd0, ovf}, 1);
    set_cfg(4, 2, 6, 0, 1, 8, 30);     arm_and_run(0, 0, 25, "R9 partial");
    chk(busy == 1'b1, "R9 busy before restart", {31'd0, busy}, 1);
    set_cfg(6, 20, 8, 1, 2, 3, 80);    arm_and_run(3, 0, 6000, "R9 restart");
    chk(ovf == 1'b0, "R9 overflow cleared by restart", {31'd0, ovf}, 0);
    set_cfg(7, 1, 12, 0, 2, 4, 90);    arm_and_run(2, 1, 6000, "R11 config jitter");
    repeat (4) step();
    chk(done == 1'b1, "R8 done held while idle", {31'd0, done}, 1);

    // random captures
    for (int t = 0; t < 20; t++) begin
      int pct;
      case ($urandom % 3)
        0: pct = 100;
        1: pct = 60;
        default: pct = 25;
      endcase
      set_cfg($urandom % 34, $urandom % 32, $urandom % 32, 1'($urandom), $urandom % 5,
              1 + $urandom % 6, pct);
      arm_and_run($urandom % 8, 1'($urandom), 6000, "random");
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule